// File: doc/BRIEF.md
# Little-Endian Address Munging Bridge

This bridge sits between a processor-side request port and a doubleword-wide external memory or I/O bus. While its mode bit is clear (big-endian, the state after reset), each request passes through with its address and data as given. While the mode bit is set (little-endian), the low offset bits of the address are XORed with a mask chosen by the access size. Byte enables are rebuilt from the altered address, and write data is steered onto the lanes those enables select. A wide access therefore places its bytes exactly where a string of single-byte munged accesses would place them.

For devices that are truly little-endian, a per-request reverse option swaps the byte lanes of the whole doubleword end to end. This swap applies to data and byte enables after munging. Read data returns through the inverse path: it is un-reversed first and un-munged second, then masked to the lanes the processor asked for.

The mode bit is held in a small register with its own write port. The block only follows that register and does not sequence the core's own mode change. Requests that are not naturally aligned are refused with an error pulse.

Top module: `le_munge_bridge`

## Requirements
- R1: After reset, mode_le is 0, ext_valid is 0, req_err is 0 and cpu_rvalid is 0.
- R2: With mode_le = 0, an aligned request appears one cycle later on ext_valid with the same ext_addr. ext_be marks lanes off..off+2^size-1, where off = addr[2:0] and lane k is data bits [8k+7:8k]. ext_wdata equals req_wdata. The size codes are 0 byte, 1 halfword, 2 word and 3 doubleword.
- R3: With mode_le = 1, a byte access (size 0) has ext_addr[2:0] = req_addr[2:0] XOR 3'b111; the upper address bits are unchanged.
- R4: With mode_le = 1, a halfword has its offset XORed with 3'b110 and a word with 3'b100; a doubleword keeps its address unchanged.
- R5: With mode_le = 1 and req_rev = 0, ext_be marks lanes moff..moff+2^size-1 of the munged offset moff. External lane j of the write data carries processor lane 7-j.
- R6: With req_rev = 1, after any munging the data lanes and the enables are both reversed, so external lane j takes lane 7-j of the munged result. In little-endian mode the two permutations cancel on data and enables.
- R7: A read response (ext_rvalid) yields cpu_rvalid one cycle later. cpu_rdata is ext_rdata un-reversed (when rev was set) and then un-munged (when little-endian), with every lane outside the processor's requested lanes forced to zero.
- R8: A request whose offset is not a multiple of 2^size raises req_err for one cycle in the following cycle, and ext_valid stays 0.
- R9: A mode write (cfg_we) updates mode_le in the next cycle. A request in the same cycle as the write uses the old mode, and the new mode applies from the next request on.
- R10: A read response is transformed with the mode and reverse setting captured when its read request was forwarded, even if the mode has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_le | input | 1 | Mode value to write (1 = little-endian) |
| mode_le | output | 1 | Current mode bit |
| req_valid | input | 1 | Processor request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Processor byte address |
| req_size | input | SZ_W | Size code: 0 byte, 1 half, 2 word, 3 doubleword |
| req_rev | input | 1 | Reverse doubleword lanes for this request |
| req_wdata | input | DATA_W | Write data in processor lane positions |
| ext_valid | output | 1 | External request valid |
| ext_write | output | 1 | External request direction |
| ext_addr | output | ADDR_W | Adjusted address |
| ext_be | output | DATA_W/8 | Adjusted byte enables |
| ext_wdata | output | DATA_W | Steered write data |
| req_err | output | 1 | Misaligned request refused |
| ext_rvalid | input | 1 | External read data valid |
| ext_rdata | input | DATA_W | External read data |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | DATA_W | Restored, masked read data |

## Verification
The bench targets the size-dependent masks at every aligned offset. A design that used one mask for all sizes would send halfwords and words to the wrong address and fail the enable checks. It issues a request in the same cycle as a mode write, which catches a mode that takes effect too early. It also changes the mode between a read and its response, so a design that un-munges with the live mode instead of the captured one returns byte-swapped data. Misaligned requests, together with masking of unrequested read lanes, show up any forwarding on error or any leakage from stale lanes.

// File: rtl/lem_pkg.sv
package lem_pkg;
    // access size codes, log2 of the byte count
    localparam int unsigned SZ_BYTE  = 0;
    localparam int unsigned SZ_HALF  = 1;
    localparam int unsigned SZ_WORD  = 2;
    localparam int unsigned SZ_DWORD = 3;
    localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/lem_mode_reg.sv
module lem_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wval,
    output logic mode
);
    logic mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (we) begin
            mode_d = wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mode_q));

    // R9
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mode_q == $past(wval)));
endmodule

// File: rtl/lem_addr_unit.sv
module lem_addr_unit #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LANES  = 8,
    parameter int unsigned SZ_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   size,
    input  logic              le,
    output logic [ADDR_W-1:0] maddr,
    output logic [LANES-1:0]  cpu_be,
    output logic [LANES-1:0]  munged_be,
    output logic              misalign
);
    localparam int unsigned OFF_W = $clog2(LANES);

    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] moff;
    logic [OFF_W:0]   span;
    logic [OFF_W-1:0] low_mask;
    logic [OFF_W-1:0] xmask;
    logic [OFF_W+1:0] lo_c, hi_c, lo_m, hi_m;

    always_comb begin
        off      = addr[OFF_W-1:0];
        span     = (OFF_W+1)'(1) << size;
        low_mask = span[OFF_W-1:0] - 1'b1;
        misalign = |(off & low_mask);
        xmask    = le ? ~low_mask : '0;
        moff     = off ^ xmask;
        maddr    = {addr[ADDR_W-1:OFF_W], moff};
        lo_c     = {2'b00, off};
        hi_c     = lo_c + {1'b0, span};
        lo_m     = {2'b00, moff};
        hi_m     = lo_m + {1'b0, span};
    end

    for (genvar j = 0; j < LANES; j++) begin : g_be
        localparam logic [OFF_W+1:0] JL = (OFF_W+2)'(j);
        assign cpu_be[j]    = (lo_c <= JL) && (JL < hi_c);
        assign munged_be[j] = (lo_m <= JL) && (JL < hi_m);
    end
endmodule

// File: rtl/lem_lane_steer.sv
module lem_lane_steer #(
    parameter int unsigned LANES   = 8,
    parameter bit          INVERSE = 1'b0
) (
    input  logic [LANES*8-1:0] din,
    input  logic [LANES-1:0]   bin,
    input  logic               le,
    input  logic               rev,
    output logic [LANES*8-1:0] dout,
    output logic [LANES-1:0]   bout
);
    localparam int unsigned LMAX = LANES - 1;

    logic [LANES*8-1:0] s1_d;
    logic [LANES-1:0]   s1_b;
    logic               en1, en2;

    // forward: munge then reverse; inverse: reverse then munge
    assign en1 = INVERSE ? rev : le;
    assign en2 = INVERSE ? le  : rev;

    for (genvar j = 0; j < LANES; j++) begin : g_s1
        localparam int unsigned MJ = j ^ LMAX;
        localparam int unsigned RJ = LMAX - j;
        localparam int unsigned I1 = INVERSE ? RJ : MJ;
        assign s1_d[j*8 +: 8] = en1 ? din[I1*8 +: 8] : din[j*8 +: 8];
        assign s1_b[j]        = en1 ? bin[I1]        : bin[j];
    end

    for (genvar j = 0; j < LANES; j++) begin : g_s2
        localparam int unsigned MJ = j ^ LMAX;
        localparam int unsigned RJ = LMAX - j;
        localparam int unsigned I2 = INVERSE ? MJ : RJ;
        assign dout[j*8 +: 8] = en2 ? s1_d[I2*8 +: 8] : s1_d[j*8 +: 8];
        assign bout[j]        = en2 ? s1_b[I2]        : s1_b[j];
    end
endmodule

// File: rtl/le_munge_bridge.sv
module le_munge_bridge #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned LANES = DATA_W / lem_pkg::BYTE_W,
    localparam int unsigned OFF_W = $clog2(LANES),
    localparam int unsigned SZ_W  = $clog2(OFF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_le,
    output logic              mode_le,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_rev,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ext_valid,
    output logic              ext_write,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [LANES-1:0]  ext_be,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              req_err,
    input  logic              ext_rvalid,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata
);
    typedef struct packed {
        logic              ext_valid;
        logic              ext_write;
        logic [ADDR_W-1:0] ext_addr;
        logic [LANES-1:0]  ext_be;
        logic [DATA_W-1:0] ext_wdata;
        logic              err;
        logic              ctx_le;
        logic              ctx_rev;
        logic [LANES-1:0]  ctx_ebe;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic              mode_q;
    logic [ADDR_W-1:0] maddr;
    logic [LANES-1:0]  cpu_be, munged_be;
    logic              misalign;
    logic [DATA_W-1:0] wr_d;
    logic [LANES-1:0]  wr_be;
    logic [DATA_W-1:0] rd_d;
    logic [LANES-1:0]  rd_be;
    logic [DATA_W-1:0] rd_mask;
    logic              fwd;

    lem_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wval  (cfg_le),
        .mode  (mode_q)
    );

    lem_addr_unit #(.ADDR_W(ADDR_W), .LANES(LANES), .SZ_W(SZ_W)) u_addr (
        .addr      (req_addr),
        .size      (req_size),
        .le        (mode_q),
        .maddr     (maddr),
        .cpu_be    (cpu_be),
        .munged_be (munged_be),
        .misalign  (misalign)
    );

    lem_lane_steer #(.LANES(LANES), .INVERSE(1'b0)) u_wr_steer (
        .din  (req_wdata),
        .bin  (cpu_be),
        .le   (mode_q),
        .rev  (req_rev),
        .dout (wr_d),
        .bout (wr_be)
    );

    lem_lane_steer #(.LANES(LANES), .INVERSE(1'b1)) u_rd_steer (
        .din  (ext_rdata),
        .bin  (st_q.ctx_ebe),
        .le   (st_q.ctx_le),
        .rev  (st_q.ctx_rev),
        .dout (rd_d),
        .bout (rd_be)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_mask
        assign rd_mask[j*8 +: 8] = {8{rd_be[j]}};
    end

    assign fwd = req_valid && !misalign;

    always_comb begin
        st_d           = st_q;
        st_d.ext_valid = 1'b0;
        st_d.err       = req_valid && misalign;
        st_d.rvalid    = 1'b0;
        if (fwd) begin
            st_d.ext_valid = 1'b1;
            st_d.ext_write = req_write;
            st_d.ext_addr  = maddr;
            st_d.ext_be    = wr_be;
            st_d.ext_wdata = req_write ? wr_d : '0;
            if (!req_write) begin
                st_d.ctx_le  = mode_q;
                st_d.ctx_rev = req_rev;
                st_d.ctx_ebe = wr_be;
            end
        end
        if (ext_rvalid) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_d & rd_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_le    = mode_q;
    assign ext_valid  = st_q.ext_valid;
    assign ext_write  = st_q.ext_write;
    assign ext_addr   = st_q.ext_addr;
    assign ext_be     = st_q.ext_be;
    assign ext_wdata  = st_q.ext_wdata;
    assign req_err    = st_q.err;
    assign cpu_rvalid = st_q.rvalid;
    assign cpu_rdata  = st_q.rdata;

    // R5
    be_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misalign && !req_rev) |-> (wr_be == munged_be));

    // R2
    fwd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misalign) |=> ext_valid);

    // R3
    byte_munge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misalign && mode_q && (req_size == '0))
        |=> (ext_addr[OFF_W-1:0] == ~$past(req_addr[OFF_W-1:0])));

    // R8
    err_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misalign) |=> (req_err && !ext_valid));

    // R7
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rvalid |=> cpu_rvalid);
endmodule

// File: tb/tb_le_munge_bridge.sv
module tb_le_munge_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_le = 1'b0;
    logic        mode_le;
    logic        req_valid = 1'b0, req_write = 1'b0, req_rev = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        ext_valid, ext_write, req_err, cpu_rvalid;
    logic [31:0] ext_addr;
    logic [7:0]  ext_be;
    logic [63:0] ext_wdata, cpu_rdata;
    logic        ext_rvalid = 1'b0;
    logic [63:0] ext_rdata = '0;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    bit m_mode = 1'b0;
    bit c_le, c_rev;
    logic [7:0] c_be;

    always #5 clk = ~clk;

    le_munge_bridge dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_le(cfg_le), .mode_le(mode_le),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_rev(req_rev), .req_wdata(req_wdata),
        .ext_valid(ext_valid), .ext_write(ext_write), .ext_addr(ext_addr),
        .ext_be(ext_be), .ext_wdata(ext_wdata), .req_err(req_err),
        .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [63:0] rev8(input logic [63:0] d);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = d[(7-k)*8 +: 8];
        return r;
    endfunction

    function automatic logic [7:0] revb(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return r;
    endfunction

    function automatic logic [7:0] lanes(input int off, input int sz);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = (k >= off) && (k < off + (1 << sz));
        return r;
    endfunction

    function automatic logic [2:0] xm(input bit le, input int sz);
        if (!le) return 3'b000;
        case (sz)
            0: return 3'b111;
            1: return 3'b110;
            2: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [63:0] bytemask(input logic [7:0] b);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = {8{b[k]}};
        return r;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // drives at a negedge, checks at the next negedge
    task automatic do_req(input bit wr, input logic [31:0] a, input int sz, input bit rv,
                          input logic [63:0] wd, input bit mode_wr, input bit mode_val,
                          input string rq);
        int off = int'(a[2:0]);
        bit mis = (off % (1 << sz)) != 0;
        logic [31:0] ea;
        logic [7:0]  eb;
        logic [63:0] ed;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = 2'(sz);
        req_rev = rv; req_wdata = wd;
        cfg_we = mode_wr; cfg_le = mode_val;
        ea = {a[31:3], a[2:0] ^ xm(m_mode, sz)};
        eb = lanes(off, sz);
        if (!wr) c_be = eb;
        if (m_mode) eb = revb(eb);
        if (rv) eb = revb(eb);
        ed = wd;
        if (m_mode) ed = rev8(ed);
        if (rv) ed = rev8(ed);
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        if (mis) begin
            chk(req_err === 1'b1 && ext_valid === 1'b0, "R8", {62'd0, req_err, ext_valid}, 64'd2);
        end else begin
            chk(ext_valid === 1'b1 && req_err === 1'b0, rq, {62'd0, ext_valid, req_err}, 64'd2);
            chk(ext_addr === ea, rq, {32'd0, ext_addr}, {32'd0, ea});
            chk(ext_be === eb, rq, {56'd0, ext_be}, {56'd0, eb});
            if (wr) chk(ext_wdata === ed, rq, ext_wdata, ed);
            if (!wr) begin c_le = m_mode; c_rev = rv; end
        end
        if (mode_wr) m_mode = mode_val;
    endtask

    task automatic do_rsp(input logic [63:0] rd, input string rq);
        logic [63:0] e;
        ext_rvalid = 1'b1; ext_rdata = rd;
        e = rd;
        if (c_rev) e = rev8(e);
        if (c_le) e = rev8(e);
        e = e & bytemask(c_be);
        @(negedge clk);
        ext_rvalid = 1'b0;
        chk(cpu_rvalid === 1'b1, "R7", {63'd0, cpu_rvalid}, 64'd1);
        chk(cpu_rdata === e, rq, cpu_rdata, e);
    endtask

    task automatic set_mode(input bit v);
        cfg_we = 1'b1; cfg_le = v;
        @(negedge clk);
        cfg_we = 1'b0;
        m_mode = v;
        chk(mode_le === v, "R9", {63'd0, mode_le}, {63'd0, v});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        chk(mode_le === 1'b0 && ext_valid === 1'b0 && req_err === 1'b0 && cpu_rvalid === 1'b0,
            "R1", {60'd0, mode_le, ext_valid, req_err, cpu_rvalid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode_le === 1'b0 && ext_valid === 1'b0, "R1", {62'd0, mode_le, ext_valid}, 64'd0);

        // big-endian pass-through, every size
        do_req(1'b1, 32'h1000_0005, 0, 1'b0, 64'h1122_3344_5566_7788, 1'b0, 1'b0, "R2");
        do_req(1'b1, 32'h1000_0006, 1, 1'b0, 64'h1122_3344_5566_7788, 1'b0, 1'b0, "R2");
        do_req(1'b1, 32'h1000_0000, 3, 1'b0, 64'h0102_0304_0506_0708, 1'b0, 1'b0, "R2");
        // R9: request in the same cycle as the mode write uses old mode
        do_req(1'b1, 32'h2000_0001, 0, 1'b0, 64'hAA, 1'b1, 1'b1, "R9");
        chk(mode_le === 1'b1, "R9", {63'd0, mode_le}, 64'd1);
        // little-endian offsets for each size
        for (int o = 0; o < 8; o++)
            do_req(1'b1, 32'h3000_0000 | 32'(o), 0, 1'b0, 64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b0, "R3");
        for (int o = 0; o < 8; o += 2)
            do_req(1'b1, 32'h3000_0010 | 32'(o), 1, 1'b0, 64'hCAFE_0123_4567_89AB, 1'b0, 1'b0, "R4");
        do_req(1'b1, 32'h3000_0020, 2, 1'b0, 64'h1111_2222_3333_4444, 1'b0, 1'b0, "R4");
        do_req(1'b1, 32'h3000_0024, 2, 1'b0, 64'h1111_2222_3333_4444, 1'b0, 1'b0, "R5");
        do_req(1'b1, 32'h3000_0028, 3, 1'b0, 64'h0102_0304_0506_0708, 1'b0, 1'b0, "R4");
        // lane reversal in both modes
        do_req(1'b1, 32'h4000_0002, 1, 1'b1, 64'h0000_0000_00BE_EF00, 1'b0, 1'b0, "R6");
        set_mode(1'b0);
        do_req(1'b1, 32'h4000_0004, 2, 1'b1, 64'h89AB_CDEF_0000_0000, 1'b0, 1'b0, "R6");
        // misaligned
        do_req(1'b1, 32'h5000_0003, 1, 1'b0, 64'h0, 1'b0, 1'b0, "R8");
        do_req(1'b0, 32'h5000_0004, 3, 1'b0, 64'h0, 1'b0, 1'b0, "R8");
        // read in big-endian, masked
        do_req(1'b0, 32'h6000_0004, 1, 1'b0, 64'h0, 1'b0, 1'b0, "R2");
        do_rsp(64'hFFEE_DDCC_BBAA_9988, "R7");
        // R10: read in little-endian, mode cleared before the response
        set_mode(1'b1);
        do_req(1'b0, 32'h6000_0001, 0, 1'b0, 64'h0, 1'b0, 1'b0, "R3");
        set_mode(1'b0);
        do_rsp(64'h0102_0304_0506_0708, "R10");
        set_mode(1'b1);
        do_req(1'b0, 32'h6000_0000, 2, 1'b1, 64'h0, 1'b0, 1'b0, "R6");
        do_rsp(64'hA1B2_C3D4_E5F6_0718, "R7");

        for (int i = 0; i < 400; i++) begin
            int sz = int'($urandom_range(3, 0));
            logic [31:0] a = $urandom();
            bit wr = $urandom_range(1, 0) == 1;
            bit rv = $urandom_range(1, 0) == 1;
            bit mis;
            if ($urandom_range(7, 0) != 0) a[2:0] = a[2:0] & ~3'((1 << sz) - 1);
            mis = (int'(a[2:0]) % (1 << sz)) != 0;
            if ($urandom_range(9, 0) == 0) set_mode(~m_mode);
            do_req(wr, a, sz, rv, {$urandom(), $urandom()}, 1'b0, 1'b0,
                   m_mode ? (rv ? "R6" : "R5") : "R2");
            if (!wr && !mis) begin
                if ($urandom_range(3, 0) == 0) set_mode(~m_mode);
                do_rsp({$urandom(), $urandom()}, "R10");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule